// File: doc/BRIEF.md
# Dual-Port Receiver Input Scanner

This block sequences the bring-up of a two-input video receiver and picks which of its two inputs is live. After its own reset it holds the receiver in reset for a fixed number of cycles. If an EDID update is pending, it opens the EDID EEPROM for writing by dropping write-protect and driving the EEPROM bus. It then restores write-protect, releases the bus and asks for receiver initialisation. Hot-plug is enabled on both inputs only when initialisation is acknowledged.

Once hot-plug is enabled, exactly one input is active at a time, and input 1 is chosen first. The block waits a dwell period for the signal-detect input to settle high. If no source shows up in that time, it moves to the other input and keeps alternating. A source counts as present after a run of consecutive high samples. The block then requests authentication and, after that is acknowledged, requests a format readout. It latches the reported colour space and depth and marks the configuration valid. If the signal drops while locked, scanning resumes on the same input with a fresh dwell.

The dwell is a cycle count, 150,000,000 by default (three seconds at 50 MHz), and can be made short for simulation.

Top module: `rx_port_scanner`

## Requirements
- R1: While the block is in reset, and for RST_CYCLES cycles after reset is released, `rcv_rst_n_o` is low. During that time both hot-plug outputs are high, no request is raised and no input is active (`port_act_o` = 0). `rcv_rst_n_o` rises RST_CYCLES cycles after release.
- R2: If `edid_update_i` is high when the receiver-reset phase ends, `eeprom_wp_o` goes low and `eeprom_bus_drive_o` goes high. Both hold until `edid_done_i` is seen. One cycle later write-protect is high again, the bus is released and `init_req_o` is high.
- R3: If `edid_update_i` is low when the receiver-reset phase ends, `eeprom_wp_o` stays high and `eeprom_bus_drive_o` stays low. `init_req_o` rises in the same cycle that `rcv_rst_n_o` rises.
- R4: Both `hpd_n_o` bits stay high (disabled) until `init_ack_i` is seen while `init_req_o` is high. One cycle after the acknowledge, both bits are low and `init_req_o` is low. Hot-plug is never enabled while the receiver is in reset or write-protect is low.
- R5: The first active input after hot-plug enable is input 1: `port_act_o` = 2'b01 and `port_sel_o` = 0.
- R6: At most one bit of `port_act_o` is ever high, and exactly one is high whenever hot-plug is enabled. Bit 0 is input 1 and bit 1 is input 2; `port_sel_o` is 0 for input 1 and 1 for input 2.
- R7: While scanning with no qualified source, the active input toggles every DWELL_CYCLES cycles. The first toggle comes DWELL_CYCLES cycles after hot-plug enable.
- R8: A source is qualified only after `sig_det_i` is high for DEBOUNCE_RUN consecutive cycles. `auth_req_o` then rises DEBOUNCE_RUN+1 cycles after the first high sample, on the same input. A shorter high run does not raise a request and does not change the toggle timing.
- R9: `auth_req_o` holds until `auth_ack_i`, and the cycle after that `fmt_req_o` is high. `fmt_req_o` holds until `fmt_ack_i`. One cycle after that, `cfg_valid_o` is high and `cfg_cspace_o`/`cfg_depth_o` hold the values present on `fmt_cspace_i`/`fmt_depth_i` during the acknowledge. The latched values do not follow later changes. The two requests are never high together.
- R10: While `cfg_valid_o` is high the active input does not change. When `sig_det_i` is sampled low, `cfg_valid_o` drops the next cycle and scanning restarts on the same input, which toggles DWELL_CYCLES cycles after the drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| edid_update_i | input | 1 | EDID update pending, sampled when receiver reset ends |
| edid_done_i | input | 1 | EDID write finished |
| eeprom_wp_o | output | 1 | EEPROM write-protect, high = protected |
| eeprom_bus_drive_o | output | 1 | High while this side owns the EEPROM serial bus; low = released |
| rcv_rst_n_o | output | 1 | Active-low receiver reset |
| init_req_o | output | 1 | Receiver initialisation request |
| init_ack_i | input | 1 | Initialisation done |
| hpd_n_o | output | 2 | Active-low hot-plug enable, one bit per input |
| port_act_o | output | 2 | One-hot active input (bit 0 = input 1) |
| port_sel_o | output | 1 | Selected input index (0 = input 1) |
| sig_det_i | input | 1 | Signal detect for the selected input |
| auth_req_o | output | 1 | Authentication request |
| auth_ack_i | input | 1 | Authentication done |
| fmt_req_o | output | 1 | Format readout request |
| fmt_ack_i | input | 1 | Format readout done, format inputs valid |
| fmt_cspace_i | input | CS_W | Reported colour space |
| fmt_depth_i | input | DEPTH_W | Reported colour depth |
| cfg_cspace_o | output | CS_W | Latched colour space |
| cfg_depth_o | output | DEPTH_W | Latched colour depth |
| cfg_valid_o | output | 1 | Link locked, configuration valid |

## Verification
Every output comes straight from registered state, so every result is due a whole number of clock edges after the stimulus:
- one edge after any acknowledge or loss of signal;
- RST_CYCLES edges after reset release;
- DWELL_CYCLES edges after hot-plug enable or a drop from lock, for an input toggle;
- DEBOUNCE_RUN+1 edges after signal detect first rises, for the authentication request.

The driver counts edges and queues each expected value with the edge number it is due on. The monitor compares on the falling edge of that exact cycle, and also in the cycle before, for the debounce and dwell limits. This way an off-by-one in any counter shows as a mismatch.

// File: rtl/rxs_pkg.sv
// Shared types for the dual-input receiver scanner.
// Assumes exactly two receiver inputs, toggled by a one-bit index.
package rxs_pkg;

    localparam int NUM_INPUTS = 2;

    typedef enum logic [2:0] {
        ST_RST  = 3'd0,   // receiver held in reset
        ST_EDID = 3'd1,   // EEPROM open for EDID write
        ST_INIT = 3'd2,   // waiting for receiver initialisation
        ST_SCAN = 3'd3,   // dwelling on one input, waiting for a source
        ST_AUTH = 3'd4,   // authentication requested
        ST_FMT  = 3'd5,   // format readout requested
        ST_LOCK = 3'd6    // link up, configuration valid
    } scan_state_t;

endpackage

// File: rtl/rxs_cycle_timer.sv
// Counts enabled cycles and pulses expire in the LIMIT-th enabled cycle.
// Assumes LIMIT >= 1; restart or expire returns the count to zero.
module rxs_cycle_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic restart,
    output logic expire
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_q;

    // Expire in the last enabled cycle of the window.
    assign expire = en && (cnt_q == W'(LIMIT - 1));

    // Advance the count while enabled, clear on restart or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || expire) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rxs_debounce.sv
// Declares a level stable after RUN consecutive high samples.
// Assumes clr drops any partial run; stable stays up while raw stays high.
module rxs_debounce #(
    parameter int RUN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic clr,
    output logic stable
);
    localparam int W = $clog2(RUN + 1);

    logic [W-1:0] run_q;

    // Stable once the run length reaches its target.
    assign stable = (run_q == W'(RUN));

    // Count consecutive high samples, saturating at the target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (clr || !raw) begin
            run_q <= '0;
        end else if (!stable) begin
            run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/rx_port_scanner.sv
// Bring-up sequencer and input scanner for a two-input video receiver.
// Order: receiver reset, optional EDID write window, initialisation,
// hot-plug enable, then dwell-based scanning, authentication, format
// readout and lock. Assumes sig_det_i reflects the selected input and
// that all request/acknowledge partners are synchronous to clk.
module rx_port_scanner
    import rxs_pkg::*;
#(
    parameter int RST_CYCLES   = 1000,
    parameter int DWELL_CYCLES = 150_000_000,
    parameter int DEBOUNCE_RUN = 16,
    parameter int CS_W         = 2,
    parameter int DEPTH_W      = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  edid_update_i,
    input  logic                  edid_done_i,
    output logic                  eeprom_wp_o,
    output logic                  eeprom_bus_drive_o,
    output logic                  rcv_rst_n_o,
    output logic                  init_req_o,
    input  logic                  init_ack_i,
    output logic [NUM_INPUTS-1:0] hpd_n_o,
    output logic [NUM_INPUTS-1:0] port_act_o,
    output logic                  port_sel_o,
    input  logic                  sig_det_i,
    output logic                  auth_req_o,
    input  logic                  auth_ack_i,
    output logic                  fmt_req_o,
    input  logic                  fmt_ack_i,
    input  logic [CS_W-1:0]       fmt_cspace_i,
    input  logic [DEPTH_W-1:0]    fmt_depth_i,
    output logic [CS_W-1:0]       cfg_cspace_o,
    output logic [DEPTH_W-1:0]    cfg_depth_o,
    output logic                  cfg_valid_o
);

    scan_state_t         state_q, state_d;
    logic                port_q;
    logic [CS_W-1:0]     cspace_q;
    logic [DEPTH_W-1:0]  depth_q;
    logic                rst_done;
    logic                dwell_exp;
    logic                src_ok;
    logic                hpd_on;
    logic                in_scan;

    assign in_scan = (state_q == ST_SCAN);

    // Receiver reset window.
    rxs_cycle_timer #(.LIMIT(RST_CYCLES)) u_rst_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (state_q == ST_RST),
        .restart (state_q != ST_RST),
        .expire  (rst_done)
    );

    // Per-input dwell window while scanning.
    rxs_cycle_timer #(.LIMIT(DWELL_CYCLES)) u_dwell_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (in_scan),
        .restart (!in_scan),
        .expire  (dwell_exp)
    );

    // Source qualification on the selected input.
    rxs_debounce #(.RUN(DEBOUNCE_RUN)) u_sig_debounce (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (sig_det_i),
        .clr    (!in_scan || dwell_exp),
        .stable (src_ok)
    );

    // Next-state selection for the bring-up sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RST:  if (rst_done)    state_d = edid_update_i ? ST_EDID : ST_INIT;
            ST_EDID: if (edid_done_i) state_d = ST_INIT;
            ST_INIT: if (init_ack_i)  state_d = ST_SCAN;
            ST_SCAN: if (src_ok)      state_d = ST_AUTH;
            ST_AUTH: if (auth_ack_i)  state_d = ST_FMT;
            ST_FMT:  if (fmt_ack_i)   state_d = ST_LOCK;
            ST_LOCK: if (!sig_det_i)  state_d = ST_SCAN;
            default:                  state_d = ST_RST;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RST;
        else        state_q <= state_d;
    end

    // Input index: starts on input 1, toggles only on an unqualified dwell expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)                            port_q <= 1'b0;
        else if (in_scan && dwell_exp && !src_ok) port_q <= ~port_q;
    end

    // Format capture on the readout acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cspace_q <= '0;
            depth_q  <= '0;
        end else if (state_q == ST_FMT && fmt_ack_i) begin
            cspace_q <= fmt_cspace_i;
            depth_q  <= fmt_depth_i;
        end
    end

    // Hot-plug is live from scanning onwards.
    assign hpd_on = (state_q == ST_SCAN) || (state_q == ST_AUTH) ||
                    (state_q == ST_FMT)  || (state_q == ST_LOCK);

    // Per-input hot-plug and active-input decode.
    for (genvar p = 0; p < NUM_INPUTS; p++) begin : g_input
        assign hpd_n_o[p]    = ~hpd_on;
        assign port_act_o[p] = hpd_on && (port_q == 1'(p));
    end

    assign port_sel_o         = port_q;
    assign rcv_rst_n_o        = (state_q != ST_RST);
    assign eeprom_wp_o        = (state_q != ST_EDID);
    assign eeprom_bus_drive_o = (state_q == ST_EDID);
    assign init_req_o         = (state_q == ST_INIT);
    assign auth_req_o         = (state_q == ST_AUTH);
    assign fmt_req_o          = (state_q == ST_FMT);
    assign cfg_valid_o        = (state_q == ST_LOCK);
    assign cfg_cspace_o       = cspace_q;
    assign cfg_depth_o        = depth_q;

endmodule

// File: rtl/rx_port_scanner_chk.sv
// Property checker for rx_port_scanner, attached by bind.
// Assumes only the top-level ports; reads no internal state.
module rx_port_scanner_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rcv_rst_n_o,
    input logic [1:0] hpd_n_o,
    input logic [1:0] port_act_o,
    input logic       init_req_o,
    input logic       auth_req_o,
    input logic       auth_ack_i,
    input logic       fmt_req_o,
    input logic       eeprom_wp_o,
    input logic       eeprom_bus_drive_o,
    input logic       cfg_valid_o
);
    // R1
    rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rcv_rst_n_o |-> (hpd_n_o == 2'b11) && !init_req_o && !auth_req_o && !fmt_req_o);

    // R2
    bus_wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eeprom_bus_drive_o |-> !eeprom_wp_o && !init_req_o);

    // R4
    hpd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hpd_n_o != 2'b11) |-> rcv_rst_n_o && eeprom_wp_o && !eeprom_bus_drive_o && !init_req_o);

    // R4
    hpd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hpd_n_o[0] == hpd_n_o[1]);

    // R6
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_act_o));

    // R6
    live_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hpd_n_o == 2'b00) |-> ($countones(port_act_o) == 1));

    // R9
    req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(auth_req_o && fmt_req_o));

    // R9
    auth_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auth_req_o && !auth_ack_i) |=> auth_req_o);

    // R10
    locked_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid_o && $past(cfg_valid_o)) |-> $stable(port_act_o));
endmodule

bind rx_port_scanner rx_port_scanner_chk u_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .rcv_rst_n_o        (rcv_rst_n_o),
    .hpd_n_o            (hpd_n_o),
    .port_act_o         (port_act_o),
    .init_req_o         (init_req_o),
    .auth_req_o         (auth_req_o),
    .auth_ack_i         (auth_ack_i),
    .fmt_req_o          (fmt_req_o),
    .eeprom_wp_o        (eeprom_wp_o),
    .eeprom_bus_drive_o (eeprom_bus_drive_o),
    .cfg_valid_o        (cfg_valid_o)
);

// File: tb/rx_port_scanner_bench.sv
// Scoreboard bench: tasks queue expected values with a due cycle,
// a falling-edge monitor compares them when due.
module rx_port_scanner_bench;

    localparam int RST_C = 8;
    localparam int DWELL = 200;
    localparam int DB    = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       edid_update_i = 1'b0, edid_done_i = 1'b0;
    logic       init_ack_i = 1'b0, sig_det_i = 1'b0;
    logic       auth_ack_i = 1'b0, fmt_ack_i = 1'b0;
    logic [1:0] fmt_cspace_i = '0, fmt_depth_i = '0;
    logic       eeprom_wp_o, eeprom_bus_drive_o, rcv_rst_n_o, init_req_o;
    logic [1:0] hpd_n_o, port_act_o;
    logic       port_sel_o, auth_req_o, fmt_req_o, cfg_valid_o;
    logic [1:0] cfg_cspace_o, cfg_depth_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int    due;
        int    id;
        int    val;
        string tag;
    } exp_t;
    exp_t sbq[$];

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) cyc = cyc + 1;

    rx_port_scanner #(
        .RST_CYCLES(RST_C), .DWELL_CYCLES(DWELL), .DEBOUNCE_RUN(DB),
        .CS_W(2), .DEPTH_W(2)
    ) u_rx_port_scanner (
        .clk(clk), .rst_n(rst_n),
        .edid_update_i(edid_update_i), .edid_done_i(edid_done_i),
        .eeprom_wp_o(eeprom_wp_o), .eeprom_bus_drive_o(eeprom_bus_drive_o),
        .rcv_rst_n_o(rcv_rst_n_o), .init_req_o(init_req_o), .init_ack_i(init_ack_i),
        .hpd_n_o(hpd_n_o), .port_act_o(port_act_o), .port_sel_o(port_sel_o),
        .sig_det_i(sig_det_i), .auth_req_o(auth_req_o), .auth_ack_i(auth_ack_i),
        .fmt_req_o(fmt_req_o), .fmt_ack_i(fmt_ack_i),
        .fmt_cspace_i(fmt_cspace_i), .fmt_depth_i(fmt_depth_i),
        .cfg_cspace_o(cfg_cspace_o), .cfg_depth_o(cfg_depth_o),
        .cfg_valid_o(cfg_valid_o)
    );

    // Observation ids: 0 rcv_rst_n, 1 hpd_n, 2 port_act, 3 auth_req, 4 fmt_req,
    // 5 cfg_valid, 6 wp, 7 bus_drive, 8 init_req, 9 {cspace,depth}, 10 port_sel
    function automatic int obs(int id);
        case (id)
            0:  return int'(rcv_rst_n_o);
            1:  return int'(hpd_n_o);
            2:  return int'(port_act_o);
            3:  return int'(auth_req_o);
            4:  return int'(fmt_req_o);
            5:  return int'(cfg_valid_o);
            6:  return int'(eeprom_wp_o);
            7:  return int'(eeprom_bus_drive_o);
            8:  return int'(init_req_o);
            9:  return int'({cfg_cspace_o, cfg_depth_o});
            10: return int'(port_sel_o);
            default: return -1;
        endcase
    endfunction

    task automatic compare(int id, int val, string tag);
        int got;
        got = obs(id);
        checks++;
        if (got !== val) begin
            errors++;
            $display("FAIL %s cycle %0d signal %0d: actual %0d expected %0d", tag, cyc, id, got, val);
        end
    endtask

    // Driver side: queue an expectation due n edges from now.
    task automatic expect_in(int n, int id, int val, string tag);
        exp_t e;
        e.due = cyc + n; e.id = id; e.val = val; e.tag = tag;
        sbq.push_back(e);
    endtask

    // Monitor: compare every queued item on its due cycle.
    always @(negedge clk) begin
        for (int i = sbq.size() - 1; i >= 0; i--) begin
            if (sbq[i].due == cyc) begin
                compare(sbq[i].id, sbq[i].val, sbq[i].tag);
                sbq.delete(i);
            end
        end
    end

    task automatic wait_until(int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic do_reset(bit upd);
        @(negedge clk);
        rst_n = 1'b0; edid_update_i = upd; edid_done_i = 1'b0; init_ack_i = 1'b0;
        sig_det_i = 1'b0; auth_ack_i = 1'b0; fmt_ack_i = 1'b0;
        repeat (3) @(negedge clk);
        // R1 state while reset is held
        compare(0, 0, "R1"); compare(1, 3, "R1"); compare(2, 0, "R1"); compare(8, 0, "R1");
        rst_n = 1'b1;
    endtask

    initial begin
        int c2, c4, c6, c7;
        do_reset(1'b1);
        expect_in(RST_C - 1, 0, 0, "R1");
        expect_in(RST_C,     0, 1, "R1");
        expect_in(RST_C - 1, 8, 0, "R1");
        expect_in(RST_C,     6, 0, "R2");
        expect_in(RST_C,     7, 1, "R2");
        expect_in(RST_C,     8, 0, "R2");
        expect_in(RST_C + 10, 6, 0, "R2");
        repeat (RST_C + 20) @(negedge clk);
        edid_done_i = 1'b1;
        expect_in(1, 6, 1, "R2"); expect_in(1, 7, 0, "R2");
        expect_in(1, 8, 1, "R2"); expect_in(1, 1, 3, "R4");
        @(negedge clk); edid_done_i = 1'b0;
        repeat (5) @(negedge clk);
        compare(1, 3, "R4"); compare(8, 1, "R4");
        init_ack_i = 1'b1; c2 = cyc;
        expect_in(1, 1, 0, "R4"); expect_in(1, 8, 0, "R4");
        expect_in(1, 2, 1, "R5"); expect_in(1, 10, 0, "R5");
        expect_in(DWELL,         2, 1, "R7");
        expect_in(DWELL + 1,     2, 2, "R7");
        expect_in(DWELL + 1,    10, 1, "R7");
        expect_in(2 * DWELL + 1, 2, 1, "R7");
        @(negedge clk); init_ack_i = 1'b0;
        // R8: a run one short of the target is ignored
        wait_until(c2 + DWELL + 10);
        sig_det_i = 1'b1;
        expect_in(DB, 3, 0, "R8"); expect_in(DB + 9, 3, 0, "R8");
        expect_in(2 * DWELL + 1 - (DWELL + 10), 2, 1, "R8");
        repeat (DB - 1) @(negedge clk);
        sig_det_i = 1'b0;
        // R8: full run qualifies the source
        wait_until(c2 + 2 * DWELL + 2);
        sig_det_i = 1'b1; c4 = cyc;
        expect_in(DB, 3, 0, "R8"); expect_in(DB + 1, 3, 1, "R8");
        expect_in(DB + 1, 2, 1, "R8");
        expect_in(DB + 14, 3, 1, "R9"); expect_in(DB + 14, 4, 0, "R9");
        wait_until(c4 + 40);
        auth_ack_i = 1'b1;
        expect_in(1, 3, 0, "R9"); expect_in(1, 4, 1, "R9");
        @(negedge clk); auth_ack_i = 1'b0;
        repeat (10) @(negedge clk);
        compare(4, 1, "R9"); compare(5, 0, "R9");
        fmt_cspace_i = 2'd2; fmt_depth_i = 2'd3; fmt_ack_i = 1'b1; c6 = cyc;
        expect_in(1, 5, 1, "R9"); expect_in(1, 9, 11, "R9"); expect_in(1, 4, 0, "R9");
        expect_in(DWELL + 100, 5, 1, "R10"); expect_in(DWELL + 100, 2, 1, "R10");
        expect_in(DWELL + 100, 9, 11, "R9");
        @(negedge clk); fmt_ack_i = 1'b0; fmt_cspace_i = 2'd0; fmt_depth_i = 2'd0;
        wait_until(c6 + DWELL + 110);
        sig_det_i = 1'b0; c7 = cyc;
        expect_in(1, 5, 0, "R10");
        expect_in(DWELL,     2, 1, "R10");
        expect_in(DWELL + 1, 2, 2, "R10");
        wait_until(c7 + DWELL + 10);
        // R3: no EDID update requested
        do_reset(1'b0);
        expect_in(RST_C - 1, 6, 1, "R3");
        expect_in(RST_C,     6, 1, "R3");
        expect_in(RST_C,     7, 0, "R3");
        expect_in(RST_C,     8, 1, "R3");
        expect_in(RST_C,     0, 1, "R3");
        repeat (RST_C + 10) @(negedge clk);
        checks++;
        if (sbq.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sbq.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog ends a hung run as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule